// File: doc/BRIEF.md
# Multicart Bank-Switching Address Mapper

This block sits between a console's CPU and picture-processor buses and the ROM chips of a bootleg multicart board. The CPU programs it by writing to a handful of decoded addresses. The block then turns every CPU program address in the upper half of memory into a program ROM address. It turns every 8KB pattern-table address from the picture processor into a character ROM address. It also drives the nametable mirroring mode.

Program space runs in one of two modes. In the first, it is four independent 8KB windows. In the second, it is a 32KB layout built from one bank value. Pattern space is split into 1KB slots, or into 2KB slot pairs. The banking mode is not held in a single mode field. It follows from which registers were written last, and a sticky flag can lock the pattern side in 1KB mode. Four scratch bytes can be written and read back.

All bank numbers are reduced modulo the configured ROM size before they drive an address. The translation is combinational from the registered state, so a register write takes effect on the cycle after its clock edge.

Top module: `mcart_bank_mapper`

## Requirements
- R1: After reset, all of the following hold:
  - program window 0 (0x8000–0x9FFF) maps to bank 0;
  - window 3 (0xE000–0xFFFF) maps to bank PRG_BANKS-1;
  - pattern slot 0 maps to bank 0;
  - `mirror_mode` is 0 (vertical);
  - every scratch byte reads 0x00.
- R2: In 8KB program mode, the three windows starting at 0x8000, 0xA000 and 0xC000 use the bank bytes written at 0x8300, 0x8301 and 0x8302. The window at 0xE000 always uses bank PRG_BANKS-1. The program ROM address is bank*8192 + (cpu_addr & 0x1FFF).
- R3: A write to 0x8000, 0xB000, 0xB0FF or 0xB1FF does three things: it stores data[5:0] as the big-bank value, it enters 32KB program mode, and it sets the 2KB-pattern flag.
- R4: In 32KB program mode, with big-bank value B:
  - windows 0 and 1 use banks 2B and 2B+1;
  - windows 2 and 3 use banks 2G and 2G+1, where G = (B & 0x30) | 0x0F.
- R5: A write to any of 0x8300–0x8302 leaves 32KB mode and returns to 8KB program mode.
- R6: A write to 0x8100 sets `mirror_mode` to data[1:0] (0 vertical, 1 horizontal, 2 single-screen lower, 3 single-screen upper). Data bit 6 is ignored, so the program mode is kept.
- R7: In 1KB pattern mode, slot k = ppu_addr[12:10] uses the byte written at 0x8310+k, ORed with (B & 0x30) << 4. The character ROM address is bank*1024 + ppu_addr[9:0].
- R8: 2KB pattern mode applies when the 2KB flag is set and the force-1KB flag is clear. In that mode, slot pairs {0,1}, {2,3}, {4,5} and {6,7} use the bytes at 0x8310, 0x8311, 0x8316 and 0x8317. The even slot of a pair uses value*2 and the odd slot uses value*2+1.
- R9: A write to any of 0x8312–0x8315 sets the force-1KB flag. Only reset clears it, so a later 0x8000 write cannot bring back 2KB mode.
- R10: Bytes at 0x5100–0x5103 read back what was last written to them. All other read addresses return 0x00, including 0x5000. A read in the same cycle as a write to that byte returns the old value.
- R11: Every computed bank number is reduced modulo PRG_BANKS (program) or CHR_BANKS (pattern) before it forms an address.
- R12: Writes to addresses outside the decoded set (for example 0x8303, 0x8318, 0x8101) change no mapping and no mirroring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address, used for register decode, readback and program translation |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, sampled on the rising edge |
| cpu_rdata | output | 8 | Read data for the scratch bytes, zero elsewhere |
| ppu_addr | input | 13 | Pattern-table address from the picture processor |
| prg_rom_addr | output | $clog2(PRG_BANKS)+13 | Translated program ROM byte address |
| chr_rom_addr | output | $clog2(CHR_BANKS)+10 | Translated character ROM byte address |
| mirror_mode | output | 2 | Nametable arrangement: 0 vertical, 1 horizontal, 2 single lower, 3 single upper |

## Verification
Two things can happen in one cycle: a register write, and a translation or readback that depends on the register being written.

The bench provokes this in two ways. It holds the picture address on pattern slot 0 while the CPU rewrites the slot-0 bank byte. It also reads a scratch byte in the same cycle that it writes that byte.

In that cycle, the scoreboard expects the old bank and the old byte. On the following probe, it expects the new ones. This shows that translation and readback follow the registered state and never the write data.

// File: rtl/mcart_pkg.sv
package mcart_pkg;

    localparam logic [15:0] ADR_BIG0   = 16'h8000;
    localparam logic [15:0] ADR_BIG1   = 16'hB000;
    localparam logic [15:0] ADR_BIG2   = 16'hB0FF;
    localparam logic [15:0] ADR_BIG3   = 16'hB1FF;
    localparam logic [15:0] ADR_MODE   = 16'h8100;
    localparam logic [15:0] ADR_PRG    = 16'h8300;
    localparam logic [15:0] ADR_CHR    = 16'h8310;
    localparam logic [15:0] ADR_SCR    = 16'h5100;

    // Banking configuration seen by the translators.
    typedef struct packed {
        logic [7:0][7:0] chr_sel;   // pattern bank bytes, index = slot
        logic [2:0][7:0] prg_sel;   // program window bytes, windows 0..2
        logic [5:0]      big_sel;   // 32KB bank value (masked to 6 bits)
        logic            wide_prg;  // 1 = 32KB program layout
        logic [1:0]      mirror;    // nametable arrangement
        logic            chr_pair;  // 2KB pattern flag
        logic            chr_lock1k;// sticky 1KB lock
    } bank_cfg_t;

    typedef struct packed {
        bank_cfg_t       cfg;
        logic [3:0][7:0] scratch;
    } reg_state_t;

    function automatic logic is_big_alias(input logic [15:0] a);
        return (a == ADR_BIG0) || (a == ADR_BIG1) ||
               (a == ADR_BIG2) || (a == ADR_BIG3);
    endfunction

endpackage

// File: rtl/mcart_regs.sv
module mcart_regs
    import mcart_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output bank_cfg_t   cfg,
    output logic [7:0]  rdata
);

    reg_state_t st_d, st_q;

    logic hit_big, hit_mode, hit_prg, hit_chr, hit_scr, hit_lock;

    always_comb begin
        hit_big  = is_big_alias(addr);
        hit_mode = (addr == ADR_MODE);
        hit_prg  = (addr[15:2] == ADR_PRG[15:2]) && (addr[1:0] != 2'b11);
        hit_chr  = (addr[15:3] == ADR_CHR[15:3]);
        hit_scr  = (addr[15:2] == ADR_SCR[15:2]);
        hit_lock = hit_chr && (addr[2:0] inside {3'd2, 3'd3, 3'd4, 3'd5});
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (hit_big) begin
                st_d.cfg.big_sel  = wdata[5:0];
                st_d.cfg.wide_prg = 1'b1;
                st_d.cfg.chr_pair = 1'b1;
            end else if (hit_mode) begin
                // bit 6 of the data is not taken: program mode is kept
                st_d.cfg.mirror = wdata[1:0];
            end else if (hit_prg) begin
                st_d.cfg.prg_sel[addr[1:0]] = wdata;
                st_d.cfg.wide_prg           = 1'b0;
            end else if (hit_chr) begin
                st_d.cfg.chr_sel[addr[2:0]] = wdata;
                if (hit_lock) begin
                    st_d.cfg.chr_lock1k = 1'b1;
                end
            end else if (hit_scr) begin
                st_d.scratch[addr[1:0]] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg   = st_q.cfg;
        rdata = hit_scr ? st_q.scratch[addr[1:0]] : 8'h00;
    end

    // R3: a big-bank write enters 32KB mode and arms the 2KB pattern flag
    a_r3_big_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_big) |=> (st_q.cfg.wide_prg && st_q.cfg.chr_pair));

    // R5: a program window write leaves 32KB mode
    a_r5_leave_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_prg) |=> !st_q.cfg.wide_prg);

    // R6: a mode write keeps the program mode
    a_r6_keep_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_mode) |=> (st_q.cfg.wide_prg == $past(st_q.cfg.wide_prg)));

    // R9: the 1KB lock never drops outside reset
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg.chr_lock1k |=> st_q.cfg.chr_lock1k);

    // R12: undecoded writes leave all state untouched
    a_r12_undecoded: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(hit_big || hit_mode || hit_prg || hit_chr || hit_scr))
        |=> (st_q == $past(st_q)));

endmodule

// File: rtl/mcart_prg_map.sv
module mcart_prg_map #(
    parameter int PRG_BANKS = 24,
    localparam int PRG_BW   = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
    localparam int PRG_AW   = PRG_BW + 13
) (
    input  logic [1:0]      win,
    input  logic [12:0]     offs,
    input  logic            wide_prg,
    input  logic [5:0]      big_sel,
    input  logic [2:0][7:0] prg_sel,
    output logic [PRG_AW-1:0] rom_addr
);

    logic [3:0][PRG_BW-1:0] win_bank;

    for (genvar w = 0; w < 4; w++) begin : g_win
        logic [31:0] raw;
        always_comb begin
            if (wide_prg) begin
                if (w < 2) begin
                    raw = 32'({big_sel, 1'b0}) + 32'(w % 2);
                end else begin
                    raw = 32'({big_sel[5:4], 4'hF, 1'b0}) + 32'(w % 2);
                end
            end else begin
                if (w < 3) begin
                    raw = 32'(prg_sel[w]);
                end else begin
                    raw = 32'(PRG_BANKS - 1);
                end
            end
            win_bank[w] = PRG_BW'(raw % 32'(PRG_BANKS));
        end
    end

    always_comb begin
        rom_addr = {win_bank[win], offs};
    end

endmodule

// File: rtl/mcart_chr_map.sv
module mcart_chr_map #(
    parameter int CHR_BANKS = 48,
    localparam int CHR_BW   = (CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1,
    localparam int CHR_AW   = CHR_BW + 10
) (
    input  logic [2:0]      slot,
    input  logic [9:0]      offs,
    input  logic            pair_mode,
    input  logic [1:0]      ext,
    input  logic [7:0][7:0] chr_sel,
    output logic [CHR_AW-1:0] rom_addr
);

    logic [7:0][CHR_BW-1:0] slot_bank;

    for (genvar s = 0; s < 8; s++) begin : g_slot
        // source byte for the slot pair: pairs 0,1 use bytes 0,1; pairs 2,3 use bytes 6,7
        localparam int PAIR_SRC = (s < 4) ? (s / 2) : (s / 2 + 4);
        logic [31:0] raw;
        always_comb begin
            if (pair_mode) begin
                raw = 32'({chr_sel[PAIR_SRC], 1'b0}) + 32'(s % 2);
            end else begin
                raw = 32'({ext, 8'h00} | {2'b00, chr_sel[s]});
            end
            slot_bank[s] = CHR_BW'(raw % 32'(CHR_BANKS));
        end
    end

    always_comb begin
        rom_addr = {slot_bank[slot], offs};
    end

endmodule

// File: rtl/mcart_bank_mapper.sv
module mcart_bank_mapper
    import mcart_pkg::*;
#(
    parameter int PRG_BANKS = 24,
    parameter int CHR_BANKS = 48,
    localparam int PRG_BW   = (PRG_BANKS > 1) ? $clog2(PRG_BANKS) : 1,
    localparam int CHR_BW   = (CHR_BANKS > 1) ? $clog2(CHR_BANKS) : 1,
    localparam int PRG_AW   = PRG_BW + 13,
    localparam int CHR_AW   = CHR_BW + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    output logic [7:0]        cpu_rdata,
    input  logic [12:0]       ppu_addr,
    output logic [PRG_AW-1:0] prg_rom_addr,
    output logic [CHR_AW-1:0] chr_rom_addr,
    output logic [1:0]        mirror_mode
);

    bank_cfg_t cfg;
    logic      pair_eff;

    mcart_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_we),
        .addr  (cpu_addr),
        .wdata (cpu_wdata),
        .cfg   (cfg),
        .rdata (cpu_rdata)
    );

    always_comb begin
        pair_eff    = cfg.chr_pair && !cfg.chr_lock1k;
        mirror_mode = cfg.mirror;
    end

    mcart_prg_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .win      (cpu_addr[14:13]),
        .offs     (cpu_addr[12:0]),
        .wide_prg (cfg.wide_prg),
        .big_sel  (cfg.big_sel),
        .prg_sel  (cfg.prg_sel),
        .rom_addr (prg_rom_addr)
    );

    mcart_chr_map #(.CHR_BANKS(CHR_BANKS)) u_chr (
        .slot      (ppu_addr[12:10]),
        .offs      (ppu_addr[9:0]),
        .pair_mode (pair_eff),
        .ext       (cfg.big_sel[5:4]),
        .chr_sel   (cfg.chr_sel),
        .rom_addr  (chr_rom_addr)
    );

    // R2: the top window in 8KB mode is pinned to the last bank
    a_r2_top_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.wide_prg && cpu_addr[15:13] == 3'b111)
        |-> (prg_rom_addr[PRG_AW-1:13] == PRG_BW'(PRG_BANKS - 1)));

    // R11: translated banks stay inside the configured ROM sizes
    a_r11_prg_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(prg_rom_addr[PRG_AW-1:13]) < 32'(PRG_BANKS));
    a_r11_chr_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(chr_rom_addr[CHR_AW-1:10]) < 32'(CHR_BANKS));

    // R10: the switch-read address returns zero
    a_r10_dip_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == 16'h5000) |-> (cpu_rdata == 8'h00));

endmodule

// File: tb/mcart_bank_mapper_test.sv
`timescale 1ns/1ps
module mcart_bank_mapper_test;

    localparam int PRG_BANKS = 24;
    localparam int CHR_BANKS = 48;
    localparam int PRG_AW = $clog2(PRG_BANKS) + 13;
    localparam int CHR_AW = $clog2(CHR_BANKS) + 10;

    localparam int K_PRG = 0, K_CHR = 1, K_MIR = 2, K_RD = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = 16'h0000;
    logic [7:0]        cpu_wdata = 8'h00;
    logic              cpu_we = 1'b0;
    logic [7:0]        cpu_rdata;
    logic [12:0]       ppu_addr = 13'h0000;
    logic [PRG_AW-1:0] prg_rom_addr;
    logic [CHR_AW-1:0] chr_rom_addr;
    logic [1:0]        mirror_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          kq[$];
    logic [31:0] eq[$];
    string       tq[$];

    always #4 clk = ~clk;

    mcart_bank_mapper #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .ppu_addr(ppu_addr),
        .prg_rom_addr(prg_rom_addr), .chr_rom_addr(chr_rom_addr),
        .mirror_mode(mirror_mode)
    );

    function automatic logic [31:0] pexp(int bank, logic [15:0] a);
        return 32'(bank) * 32'd8192 + 32'(a & 16'h1FFF);
    endfunction

    function automatic logic [31:0] cexp(int bank, logic [12:0] a);
        return 32'(bank) * 32'd1024 + 32'(a & 13'h03FF);
    endfunction

    task automatic push(int k, logic [31:0] e, string t);
        kq.push_back(k);
        eq.push_back(e);
        tq.push_back(t);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(posedge clk); #1;
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); #1;
        cpu_we = 1'b0;
    endtask

    // write with a same-cycle expectation
    task automatic wr_chk(logic [15:0] a, logic [7:0] d, int k, logic [31:0] e, string t);
        @(posedge clk); #1;
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        push(k, e, t);
        @(posedge clk); #1;
        cpu_we = 1'b0;
    endtask

    task automatic pp(logic [15:0] a, int bank, string t);
        @(posedge clk); #1;
        cpu_addr = a;
        push(K_PRG, pexp(bank, a), t);
    endtask

    task automatic pc(logic [12:0] a, int bank, string t);
        @(posedge clk); #1;
        ppu_addr = a;
        push(K_CHR, cexp(bank, a), t);
    endtask

    task automatic pm(int m, string t);
        @(posedge clk); #1;
        push(K_MIR, 32'(m), t);
    endtask

    task automatic pr(logic [15:0] a, logic [7:0] d, string t);
        @(posedge clk); #1;
        cpu_addr = a;
        push(K_RD, 32'(d), t);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; cpu_we = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // monitor: one expected item per cycle, judged mid-cycle
    always @(negedge clk) begin
        if (kq.size() > 0) begin
            int          k;
            logic [31:0] e, act;
            string       t;
            k = kq.pop_front();
            e = eq.pop_front();
            t = tq.pop_front();
            case (k)
                K_PRG:   act = 32'(prg_rom_addr);
                K_CHR:   act = 32'(chr_rom_addr);
                K_MIR:   act = 32'(mirror_mode);
                default: act = 32'(cpu_rdata);
            endcase
            checks++;
            if (act !== e) begin
                errors++;
                $display("FAIL %s: got %0h expected %0h", t, act, e);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        pp(16'h8000, 0, "R1 window0");
        pp(16'hE000, PRG_BANKS - 1, "R1 window3");
        pc(13'h0000, 0, "R1 slot0");
        pm(0, "R1 mirror");
        pr(16'h5101, 8'h00, "R1 scratch");

        // R2 8KB mode
        wr(16'h8300, 8'd5);
        wr(16'h8301, 8'd7);
        wr(16'h8302, 8'd3);
        pp(16'h8010, 5, "R2 window0");
        pp(16'hA000, 7, "R2 window1");
        pp(16'hC123, 3, "R2 window2");
        pp(16'hFFFF, PRG_BANKS - 1, "R2 window3 fixed");

        // R3 R4 32KB mode via each alias, with R11 wrap of banks
        wr(16'h8000, 8'd2);
        pp(16'h8000, 4, "R4 win0 via 8000");
        pp(16'hA000, 5, "R4 win1 via 8000");
        pp(16'hC000, 6, "R4 win2 group R11");
        pp(16'hE000, 7, "R4 win3 group R11");
        wr(16'hB0FF, 8'h35);
        pp(16'h8000, 10, "R3 alias B0FF win0");
        pp(16'hE000, 7, "R3 alias B0FF win3");
        wr(16'hB000, 8'h12);
        pp(16'hA000, 13, "R3 alias B000 win1");
        pp(16'hC000, 14, "R3 alias B000 win2");
        wr(16'hB1FF, 8'h21);
        pp(16'h8000, 18, "R3 alias B1FF win0");
        pp(16'hE000, 23, "R3 alias B1FF win3");

        // R6 mirroring while in 32KB mode
        wr(16'h8100, 8'h03);
        pm(3, "R6 mirror single upper");
        pp(16'h8000, 18, "R6 wide kept");

        // R5 back to 8KB
        wr(16'h8301, 8'd9);
        pp(16'h8000, 5, "R5 window0");
        pp(16'hA000, 9, "R5 window1");
        pp(16'hE000, PRG_BANKS - 1, "R5 window3");
        wr(16'h8100, 8'h42);
        pm(2, "R6 mirror single lower");
        pp(16'hC000, 3, "R6 bit6 ignored");
        wr(16'h8100, 8'h41);
        pm(1, "R6 mirror horizontal");
        pp(16'h8000, 5, "R6 stays 8KB");

        // R12 undecoded writes
        wr(16'h8303, 8'h11);
        wr(16'h8318, 8'h22);
        wr(16'h8101, 8'h03);
        pp(16'h8000, 5, "R12 window0");
        pp(16'hC000, 3, "R12 window2");
        pm(1, "R12 mirror");

        // R8 2KB pattern mode (flag set, no lock), big bank 0x21
        wr(16'h8310, 8'd3);
        wr(16'h8311, 8'd4);
        wr(16'h8316, 8'd10);
        wr(16'h8317, 8'd25);
        pc(13'h0000, 6, "R8 slot0");
        pc(13'h0400, 7, "R8 slot1");
        pc(13'h0800, 8, "R8 slot2");
        pc(13'h0C55, 9, "R8 slot3");
        pc(13'h1000, 20, "R8 slot4");
        pc(13'h1400, 21, "R8 slot5");
        pc(13'h1800, 2, "R8 slot6 R11");
        pc(13'h1C00, 3, "R8 slot7 R11");

        // R9 lock, R7 1KB with extension bits
        wr(16'h8314, 8'd7);
        pc(13'h0000, 35, "R7 slot0 ext");
        pc(13'h0400, 36, "R7 slot1 ext");
        pc(13'h1000, 39, "R7 slot4 ext");
        pc(13'h1C00, 9, "R7 slot7 ext");
        wr(16'h8000, 8'h00);
        pc(13'h0000, 3, "R9 lock sticky slot0");
        pc(13'h1800, 10, "R9 lock sticky slot6");
        pc(13'h1C00, 25, "R9 lock sticky slot7");
        pp(16'h8000, 0, "R4 bank0 win0");
        pp(16'hE000, 7, "R4 bank0 win3");
        wr(16'h8315, 8'h3F);
        pc(13'h1400, 15, "R11 slot5 wrap");

        // R10 scratch
        wr(16'h5100, 8'hAB);
        wr(16'h5101, 8'hCD);
        wr(16'h5102, 8'hEF);
        wr(16'h5103, 8'h12);
        pr(16'h5100, 8'hAB, "R10 scratch0");
        pr(16'h5101, 8'hCD, "R10 scratch1");
        pr(16'h5102, 8'hEF, "R10 scratch2");
        pr(16'h5103, 8'h12, "R10 scratch3");
        pr(16'h5000, 8'h00, "R10 switch read");
        pr(16'h5104, 8'h00, "R10 outside range");
        wr_chk(16'h5101, 8'h99, K_RD, 32'h0000_00CD, "R10 same-cycle old value");
        pr(16'h5101, 8'h99, "R10 new value");

        // R1 after a second reset; lock cleared
        do_reset();
        pp(16'h8000, 0, "R1 again window0");
        pp(16'hE000, PRG_BANKS - 1, "R1 again window3");
        pm(0, "R1 again mirror");
        pr(16'h5100, 8'h00, "R1 again scratch");
        wr(16'h8000, 8'h00);
        wr(16'h8310, 8'd3);
        pc(13'h0000, 6, "R9 reset clears lock");
        wr_chk(16'h8310, 8'd5, K_CHR, cexp(6, 13'h0000), "R8 same-cycle old bank");
        pc(13'h0000, 10, "R8 new bank");
        pc(13'h0400, 11, "R8 new bank odd");

        @(posedge clk);
        while (kq.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule